// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the synchronized input values of one GPIO bank and turns selected pin activity into a single interrupt request. For every pin, software picks level or edge sensing, the active level or edge direction, and optionally "both edges". Every clock, each pin is compared against its configuration. A match sets that pin's sticky status bit. The interrupt line is raised whenever a status bit is set and the same pin is not masked.

Software reaches the block through a simple word-addressed register port: `wr_en`, `addr`, `wr_data` for writes and a combinational `rd_data` for reads. The mask cannot be written directly. Two write-one-only ports clear or set mask bits, so one pin can be enabled or disabled without a read-modify-write. Status bits are cleared by writing ones to the status address.

Top module: `gpi_irq_unit`

## Requirements
- R1: Address map (3-bit `addr`): 0 mask (read only), 1 unmask port, 2 mask-set port, 3 status, 4 sense kind, 5 polarity, 6 both-edges. Ports 1 and 2 and address 7 read as zero. A write to address 1 clears every mask bit whose `wr_data` bit is 1. Zero bits leave the mask unchanged.
- R2: A write to address 2 sets every mask bit whose `wr_data` bit is 1. Writing all ones masks every pin.
- R3: Status bits are sticky. A write to address 3 clears the bits written as 1, and bits written as 0 keep their value.
- R4: A sense-kind bit of 1 makes the pin edge sensitive, and 0 makes it level sensitive. An edge sets status at the clock edge where the new pin value is first sampled.
- R5: A polarity bit of 1 selects a rising edge or a high level. A polarity bit of 0 selects a falling edge or a low level.
- R6: A both-edges bit of 1 on an edge-sensitive pin triggers on both rising and falling edges, whatever the polarity. The bit has no effect on level-sensitive pins.
- R7: A level-sensitive pin sets its status bit on every clock while its active level is present, so a clear made during that time does not last.
- R8: Status latches whether or not the pin is masked. `irq` is high exactly when some status bit is 1 and its mask bit is 0, where a mask bit of 1 blocks the pin.
- R9: When a status clear and a new event hit the same bit in the same cycle, the bit stays 1.
- R10: Reset sets the mask to all ones and clears status, sense kind, polarity and both-edges to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS | Synchronized pin values |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | NPINS | Write data |
| rd_data | output | NPINS | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `pin_in` is already synchronous to `clk` and that `wr_en`, `addr` and `wr_data` are stable around each rising edge. The mask assertions also assume that one write never targets both mask ports. The bench changes all inputs a fixed delay after the falling edge and issues one write at a time. It therefore stays within these assumptions, while still placing a status clear and a pin edge in the same cycle.

// File: rtl/gpi_pkg.sv
package gpi_pkg;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] ADDR_MASK    = 3'd0;
   localparam logic [ADDR_W-1:0] ADDR_UNMASK  = 3'd1;
   localparam logic [ADDR_W-1:0] ADDR_SETMASK = 3'd2;
   localparam logic [ADDR_W-1:0] ADDR_STATUS  = 3'd3;
   localparam logic [ADDR_W-1:0] ADDR_KIND    = 3'd4;
   localparam logic [ADDR_W-1:0] ADDR_POL     = 3'd5;
   localparam logic [ADDR_W-1:0] ADDR_BOTH    = 3'd6;
endpackage

// File: rtl/gpi_cfg_regs.sv
module gpi_cfg_regs
   import gpi_pkg::*;
#(
   parameter int NPINS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [NPINS-1:0]  wr_data,
   output logic [NPINS-1:0]  kind_q,
   output logic [NPINS-1:0]  pol_q,
   output logic [NPINS-1:0]  both_q,
   output logic [NPINS-1:0]  mask_q
);
   localparam logic [NPINS-1:0] ALL_ONES = {NPINS{1'b1}};

   // sensing configuration: plain read/write words
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= '0;
         pol_q  <= '0;
         both_q <= '0;
      end else if (wr_en) begin
         if (addr == ADDR_KIND) kind_q <= wr_data;
         if (addr == ADDR_POL)  pol_q  <= wr_data;
         if (addr == ADDR_BOTH) both_q <= wr_data;
      end
   end

   // mask: only reachable through the two write-one ports
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= ALL_ONES;
      end else if (wr_en) begin
         if (addr == ADDR_UNMASK)  mask_q <= mask_q & ~wr_data;
         if (addr == ADDR_SETMASK) mask_q <= mask_q | wr_data;
      end
   end
endmodule

// File: rtl/gpi_event_detect.sv
module gpi_event_detect #(
   parameter int NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_in,
   input  logic [NPINS-1:0] kind,
   input  logic [NPINS-1:0] pol,
   input  logic [NPINS-1:0] both,
   output logic [NPINS-1:0] ev
);
   logic [NPINS-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_in;
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic rise, fall, lvl_hit, edge_hit;
      always_comb begin
         rise     = pin_in[i] & ~prev_q[i];
         fall     = ~pin_in[i] & prev_q[i];
         lvl_hit  = pol[i] ? pin_in[i] : ~pin_in[i];
         if (both[i]) edge_hit = rise | fall;
         else         edge_hit = pol[i] ? rise : fall;
         ev[i]    = kind[i] ? edge_hit : lvl_hit;
      end
   end
endmodule

// File: rtl/gpi_status_irq.sv
module gpi_status_irq #(
   parameter int NPINS   = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] ev,
   input  logic             clr_en,
   input  logic [NPINS-1:0] clr_bits,
   input  logic [NPINS-1:0] mask,
   output logic [NPINS-1:0] status_q,
   output logic             irq
);
   logic [NPINS-1:0] clr_vec;
   logic             pend_any;

   assign clr_vec = clr_en ? clr_bits : '0;

   // new events take priority over a clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & ~clr_vec) | ev;
   end

   assign pend_any = |(status_q & ~mask);

   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pend_any;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = pend_any;
   end
endmodule

// File: rtl/gpi_irq_unit.sv
module gpi_irq_unit
   import gpi_pkg::*;
#(
   parameter int NPINS   = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pin_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [NPINS-1:0]  wr_data,
   output logic [NPINS-1:0]  rd_data,
   output logic              irq
);
   initial begin
      assert (NPINS >= 1 && NPINS <= 64)
         else $error("gpi_irq_unit: NPINS must lie in 1..64");
   end

   logic [NPINS-1:0] kind_q, pol_q, both_q, mask_q;
   logic [NPINS-1:0] ev_w, status_q;
   logic             st_clr;

   gpi_cfg_regs #(.NPINS(NPINS)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .kind_q(kind_q), .pol_q(pol_q),
      .both_q(both_q), .mask_q(mask_q)
   );

   gpi_event_detect #(.NPINS(NPINS)) u_det (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .kind(kind_q),
      .pol(pol_q), .both(both_q), .ev(ev_w)
   );

   assign st_clr = wr_en && (addr == ADDR_STATUS);

   gpi_status_irq #(.NPINS(NPINS), .IRQ_REG(IRQ_REG)) u_st (
      .clk(clk), .rst_n(rst_n), .ev(ev_w), .clr_en(st_clr),
      .clr_bits(wr_data), .mask(mask_q), .status_q(status_q), .irq(irq)
   );

   always_comb begin
      case (addr)
         ADDR_MASK:   rd_data = mask_q;
         ADDR_STATUS: rd_data = status_q;
         ADDR_KIND:   rd_data = kind_q;
         ADDR_POL:    rd_data = pol_q;
         ADDR_BOTH:   rd_data = both_q;
         default:     rd_data = '0;
      endcase
   end
endmodule

// File: rtl/gpi_irq_chk.sv
module gpi_irq_chk
   import gpi_pkg::*;
#(
   parameter int NPINS   = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [NPINS-1:0]  wr_data,
   input logic [NPINS-1:0]  ev_w,
   input logic [NPINS-1:0]  status_q,
   input logic [NPINS-1:0]  mask_q,
   input logic              irq
);
   // R1
   unmask_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_UNMASK) |=> ((mask_q & $past(wr_data)) == '0));

   // R2
   setmask_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_SETMASK) |=> ((mask_q & $past(wr_data)) == $past(wr_data)));

   // R3
   status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(status_q) & ~status_q) != '0) |->
         ($past(wr_en) && $past(addr) == ADDR_STATUS &&
          (($past(status_q) & ~status_q & ~$past(wr_data)) == '0))));

   // R9
   event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_STATUS) |=> ((status_q & $past(ev_w)) == $past(ev_w)));

   if (!IRQ_REG) begin : g_comb_irq
      // R8
      irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq == ((status_q & ~mask_q) != '0));
   end
endmodule

bind gpi_irq_unit gpi_irq_chk #(.NPINS(NPINS), .IRQ_REG(IRQ_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
   .ev_w(ev_w), .status_q(status_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/sim_gpi_irq_unit.sv
`timescale 1ns/1ps
module sim_gpi_irq_unit;
   localparam int N = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pin_in = '0;
   logic          wr_en = 1'b0;
   logic [2:0]    addr = 3'd0;
   logic [N-1:0]  wr_data = '0;
   logic [N-1:0]  rd_data;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   gpi_irq_unit u0 (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
   );

   // behavioural reference model
   bit [N-1:0] m_mask, m_stat, m_kind, m_pol, m_both, m_prev;

   always @(posedge clk) begin
      bit [N-1:0] hit;
      if (!rst_n) begin
         m_mask = '1; m_stat = '0; m_kind = '0; m_pol = '0; m_both = '0; m_prev = '0;
      end else begin
         hit = '0;
         for (int i = 0; i < N; i++) begin
            bit now, was;
            now = pin_in[i]; was = m_prev[i];
            if (m_kind[i] == 1'b0) hit[i] = (now == m_pol[i]);
            else if (m_both[i])    hit[i] = (now != was);
            else if (m_pol[i])     hit[i] = now && !was;
            else                   hit[i] = !now && was;
         end
         if (wr_en) begin
            case (addr)
               3'd1: m_mask = m_mask & ~wr_data;
               3'd2: m_mask = m_mask | wr_data;
               3'd3: m_stat = m_stat & ~wr_data;
               3'd4: m_kind = wr_data;
               3'd5: m_pol  = wr_data;
               3'd6: m_both = wr_data;
               default: ;
            endcase
         end
         m_stat = m_stat | hit;
         m_prev = pin_in;
      end
   end

   function automatic bit [N-1:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return m_mask;
         3'd3: return m_stat;
         3'd4: return m_kind;
         3'd5: return m_pol;
         3'd6: return m_both;
         default: return '0;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] a);
      case (a)
         3'd0: return "R2";
         3'd3: return "R3";
         3'd4: return "R4";
         3'd5: return "R5";
         3'd6: return "R6";
         default: return "R1";
      endcase
   endfunction

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // compare with the model every clock, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(tag_of(addr), rd_data, m_read(addr));
         check("R8", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, (m_stat & ~m_mask) != '0});
      end
   end

   task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
      @(negedge clk); #2;
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk); #2;
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pins(input logic [N-1:0] v);
      @(negedge clk); #2;
      pin_in = v;
   endtask

   task automatic expect_rd(input string req, input logic [2:0] a, input logic [N-1:0] exp);
      @(negedge clk); #2;
      addr = a;
      @(negedge clk); #1;
      check(req, rd_data, exp);
   endtask

   task automatic expect_irq(input string req, input logic exp);
      @(negedge clk); #1;
      check(req, {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, exp});
   endtask

   initial begin
      #(8 * 20000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #2 rst_n = 1'b1;
      // R10 reset values
      expect_rd("R10", 3'd0, 32'hFFFF_FFFF);
      expect_rd("R10", 3'd4, 32'h0);
      expect_rd("R10", 3'd5, 32'h0);
      expect_rd("R10", 3'd6, 32'h0);
      expect_irq("R8", 1'b0);
      // R5 level low is the reset polarity: all low pins latch
      expect_rd("R5", 3'd3, 32'hFFFF_FFFF);
      wr(3'd5, 32'hFFFF_FFFF);
      wr(3'd3, 32'hFFFF_FFFF);
      expect_rd("R3", 3'd3, 32'h0);
      // R1 unmask and zero-bit writes
      wr(3'd1, 32'h0000_00FF);
      expect_rd("R1", 3'd0, 32'hFFFF_FF00);
      wr(3'd1, 32'h0);
      expect_rd("R1", 3'd0, 32'hFFFF_FF00);
      expect_rd("R1", 3'd1, 32'h0);
      // R5 level high, R8 irq
      pins(32'h1);
      expect_rd("R5", 3'd3, 32'h1);
      expect_irq("R8", 1'b1);
      pins(32'h0);
      expect_rd("R3", 3'd3, 32'h1);
      wr(3'd3, 32'h0);
      expect_rd("R3", 3'd3, 32'h1);
      wr(3'd3, 32'h1);
      expect_rd("R3", 3'd3, 32'h0);
      // R7 persistent level
      pins(32'h2);
      wr(3'd3, 32'h2);
      expect_rd("R7", 3'd3, 32'h2);
      pins(32'h0);
      wr(3'd3, 32'hFFFF_FFFF);
      expect_rd("R7", 3'd3, 32'h0);
      // R4 edge sensing, R5 direction, R6 both edges
      wr(3'd4, 32'hFFFF_FFFF);
      wr(3'd5, 32'h1);
      wr(3'd6, 32'h4);
      wr(3'd3, 32'hFFFF_FFFF);
      pins(32'h7);
      expect_rd("R4", 3'd3, 32'h5);
      wr(3'd3, 32'hFFFF_FFFF);
      expect_rd("R4", 3'd3, 32'h0);
      pins(32'h0);
      expect_rd("R6", 3'd3, 32'h6);
      wr(3'd3, 32'hFFFF_FFFF);
      // R9 clear and rising edge in the same cycle
      @(negedge clk); #2;
      pin_in = 32'h1; wr_en = 1'b1; addr = 3'd3; wr_data = 32'h1;
      @(negedge clk); #2;
      wr_en = 1'b0; wr_data = '0;
      expect_rd("R9", 3'd3, 32'h1);
      pins(32'h0);
      wr(3'd3, 32'hFFFF_FFFF);
      expect_rd("R9", 3'd3, 32'h0);
      // R6 both-edges has no effect on a level pin
      wr(3'd5, 32'h9);
      wr(3'd4, 32'hFFFF_FFF7);
      wr(3'd6, 32'hC);
      wr(3'd3, 32'hFFFF_FFFF);
      pins(32'h8);
      expect_rd("R6", 3'd3, 32'h8);
      pins(32'h0);
      wr(3'd3, 32'hFFFF_FFFF);
      expect_rd("R6", 3'd3, 32'h0);
      // R2 mask all, R8 status latches while masked
      wr(3'd2, 32'hFFFF_FFFF);
      expect_rd("R2", 3'd0, 32'hFFFF_FFFF);
      pins(32'h8);
      expect_rd("R8", 3'd3, 32'h8);
      expect_irq("R8", 1'b0);
      wr(3'd1, 32'h8);
      expect_irq("R8", 1'b1);
      wr(3'd2, 32'h0);
      expect_rd("R2", 3'd0, 32'hFFFF_FFF7);
      repeat (4) @(negedge clk);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule